// File: doc/BRIEF.md
# Thruster Arm/Fire Pulse Controller

This block drives a bank of thruster valve outputs and a pair of isolation valve outputs for a small free-flying vehicle. Software reaches it through a synchronous register port. A thruster opens only after two separate writes: one sets its bit in the arm mask, and a later write sends a fire command for the same bit. Once a fire command is accepted, the hardware holds the valve open for a programmed number of clock cycles and then closes it. Software never clears the output itself.

Each thruster channel has its own watchdog. The watchdog counts how many cycles in a row the valve has been open. If software keeps retriggering a channel until the on-time reaches a fixed limit, the watchdog forces that channel off. It then records a sticky fault, and the channel refuses further fire commands until software clears the fault. If software commands either isolation valve closed, every thruster is killed and the arm mask is wiped. A fire command aimed at a channel that is not armed raises a sticky command-reject flag.

Register map (3-bit address, 32-bit data, reads are registered and appear one cycle after the address):

- 0 holds the arm mask, one bit per thruster.
- 1 takes the fire command on a write, one bit per thruster. A read returns which channels have a pulse in progress.
- 2 holds the pulse duration in cycles.
- 3 holds the isolation valve bits, where bit k = 1 means valve k is open.
- 4 is the status register: bits [N-1:0] are the watchdog faults and bit 31 is the reject flag. All of its bits are cleared by writing 1.
- Any other address reads as zero.

Top module: `thr_pulse_ctrl`

## Requirements
- R1: After reset, all thruster outputs are low and both isolation outputs are low (closed). The arm, duration, isolation and status registers all read 0.
- R2: A thruster output rises only in the cycle after a write of 1 to its bit at address 1. The write is accepted only if that channel's arm bit is set, both isolation bits are 1, the channel has no fault, and the duration is non-zero.
- R3: An accepted fire command holds the output high for exactly as many cycles as the duration register value. After that the output drops, and the channel's fire bit reads back as 0 at address 1.
- R4: A fire command issued while the duration is 0 is ignored. No pulse starts and no reject is flagged.
- R5: A fire command to a channel that is already pulsing reloads its counter. The output stays high continuously until the new duration runs out.
- R6: When a channel has been high for WD_LIMIT consecutive cycles, its output drops. Its fault bit in status [N-1:0] is then set and stays set.
- R7: A faulted channel ignores fire commands until software writes 1 to its status fault bit. After that it pulses normally again.
- R8: A write to address 3 with either of bits [1:0] at 0 clears the whole arm mask. While either isolation bit is 0, every thruster output is low and a pending pulse is cancelled.
- R9: A fire command containing a 1 for an unarmed channel sets status bit 31. The bit stays set until software writes 1 to it.
- R10: Clearing a channel's arm bit drops its output in the cycle the arm register changes. Re-arming the channel does not resume the cancelled pulse.
- R11: Register reads return the value one cycle after the address is presented. The duration register reads back only its DUR_W low bits, and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| thr_on | output | N_THR | Thruster valve drive, 1 = open |
| iso_open | output | N_ISO | Isolation valve drive, 1 = open |

## Verification
The bench counts how many cycles each pulse is high. A counter that is off by one would give D-1 or D+1 cycles instead of D. A retrigger that failed to reload would cut the pulse short. The watchdog test keeps retriggering one channel until it trips. A watchdog that never tripped, or that tripped one cycle early or late, would show up in the measured high-time, and a fault that was not sticky would let the later refire through. The kill paths are checked after each one takes effect: closing an isolation valve, and clearing an arm bit in the middle of a pulse. A design that only masked the output and kept the pulse state would turn the valve back on when the gate reopened. The bench also fires mixed armed and unarmed masks, and issues a fire command with a zero duration. This catches a reject flag raised for the wrong reason, or a zero duration that loads a counter which then wraps.

// File: rtl/thr_pkg.sv
package thr_pkg;

    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned REJ_BIT = 31;

    typedef enum logic [ADDR_W-1:0] {
        RA_ARM  = 3'd0,
        RA_FIRE = 3'd1,
        RA_DUR  = 3'd2,
        RA_ISO  = 3'd3,
        RA_STAT = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_cmd_t;

    function automatic bit cmd_hits(input reg_cmd_t c, input reg_addr_e a);
        return c.wr && (c.addr == a);
    endfunction

endpackage

// File: rtl/thr_channel.sv
module thr_channel
    import thr_pkg::*;
#(
    parameter int unsigned DUR_W    = 16,
    parameter int unsigned WD_LIMIT = 100000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_cmd,
    input  logic [DUR_W-1:0] dur,
    input  logic             armed,
    input  logic             iso_ok,
    input  logic             fault_clr,
    output logic             on,
    output logic             fire_st,
    output logic             fault,
    output logic             reject
);
    localparam int unsigned WD_W = $clog2(WD_LIMIT + 1);

    logic             fire_q;
    logic [DUR_W-1:0] cnt_q;
    logic [WD_W-1:0]  wd_q;
    logic             fault_q;
    logic             accept;
    logic             trip;

    assign accept  = fire_cmd && armed && iso_ok && !fault_q && (dur != '0);
    assign on      = fire_q && armed && iso_ok;
    assign trip    = on && (wd_q == WD_W'(WD_LIMIT - 1));
    assign fire_st = fire_q;
    assign fault   = fault_q;
    assign reject  = fire_cmd && !armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            fire_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!armed || !iso_ok || trip) begin
            fire_q <= 1'b0;
        end else if (accept) begin
            fire_q <= 1'b1;
            cnt_q  <= dur;
        end else if (fire_q) begin
            if (cnt_q <= DUR_W'(1)) fire_q <= 1'b0;
            cnt_q <= cnt_q - DUR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || trip || !on) wd_q <= '0;
        else                    wd_q <= wd_q + WD_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)            fault_q <= 1'b0;
        else if (trip)      fault_q <= 1'b1;
        else if (fault_clr) fault_q <= 1'b0;
    end

endmodule

// File: rtl/thr_regbank.sv
module thr_regbank
    import thr_pkg::*;
#(
    parameter int unsigned N_THR = 12,
    parameter int unsigned N_ISO = 2,
    parameter int unsigned DUR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_cmd_t          cmd,
    input  logic [N_THR-1:0]  fire_st,
    input  logic [N_THR-1:0]  fault_v,
    input  logic [N_THR-1:0]  reject_v,
    output logic [N_THR-1:0]  arm_q,
    output logic [DUR_W-1:0]  dur_q,
    output logic [N_ISO-1:0]  iso_q,
    output logic              rej_q,
    output logic [N_THR-1:0]  fire_cmd,
    output logic [N_THR-1:0]  fault_clr,
    output logic [DATA_W-1:0] rdata
);
    logic              iso_close;
    logic [DATA_W-1:0] rd_n;
    logic              unused_wdata;

    assign unused_wdata = ^cmd.data;
    assign iso_close    = cmd_hits(cmd, RA_ISO) && !(&cmd.data[N_ISO-1:0]);
    assign fire_cmd     = cmd_hits(cmd, RA_FIRE) ? cmd.data[N_THR-1:0] : '0;
    assign fault_clr    = cmd_hits(cmd, RA_STAT) ? cmd.data[N_THR-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst || iso_close)          arm_q <= '0;
        else if (cmd_hits(cmd, RA_ARM)) arm_q <= cmd.data[N_THR-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dur_q <= '0;
            iso_q <= '0;
        end else begin
            if (cmd_hits(cmd, RA_DUR)) dur_q <= cmd.data[DUR_W-1:0];
            if (cmd_hits(cmd, RA_ISO)) iso_q <= cmd.data[N_ISO-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                           rej_q <= 1'b0;
        else if (|reject_v)                                rej_q <= 1'b1;
        else if (cmd_hits(cmd, RA_STAT) && cmd.data[REJ_BIT]) rej_q <= 1'b0;
    end

    always_comb begin
        rd_n = '0;
        case (reg_addr_e'(cmd.addr))
            RA_ARM:  rd_n[N_THR-1:0] = arm_q;
            RA_FIRE: rd_n[N_THR-1:0] = fire_st;
            RA_DUR:  rd_n[DUR_W-1:0] = dur_q;
            RA_ISO:  rd_n[N_ISO-1:0] = iso_q;
            RA_STAT: begin
                rd_n[N_THR-1:0] = fault_v;
                rd_n[REJ_BIT]   = rej_q;
            end
            default: rd_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) rdata <= '0;
        else     rdata <= rd_n;
    end

endmodule

// File: rtl/thr_pulse_ctrl.sv
module thr_pulse_ctrl
    import thr_pkg::*;
#(
    parameter int unsigned N_THR    = 12,
    parameter int unsigned N_ISO    = 2,
    parameter int unsigned DUR_W    = 16,
    parameter int unsigned WD_LIMIT = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [N_THR-1:0]  thr_on,
    output logic [N_ISO-1:0]  iso_open
);
    reg_cmd_t           cmd;
    logic [N_THR-1:0]   arm_q;
    logic [DUR_W-1:0]   dur_q;
    logic [N_ISO-1:0]   iso_q;
    logic               rej_q;
    logic [N_THR-1:0]   fire_cmd;
    logic [N_THR-1:0]   fault_clr;
    logic [N_THR-1:0]   fire_st;
    logic [N_THR-1:0]   fault_v;
    logic [N_THR-1:0]   reject_v;
    logic               iso_ok;

    assign cmd      = '{wr: reg_wr, addr: reg_addr, data: reg_wdata};
    assign iso_ok   = &iso_q;
    assign iso_open = iso_q;

    thr_regbank #(.N_THR(N_THR), .N_ISO(N_ISO), .DUR_W(DUR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .fire_st   (fire_st),
        .fault_v   (fault_v),
        .reject_v  (reject_v),
        .arm_q     (arm_q),
        .dur_q     (dur_q),
        .iso_q     (iso_q),
        .rej_q     (rej_q),
        .fire_cmd  (fire_cmd),
        .fault_clr (fault_clr),
        .rdata     (reg_rdata)
    );

    for (genvar i = 0; i < N_THR; i++) begin : g_ch
        thr_channel #(.DUR_W(DUR_W), .WD_LIMIT(WD_LIMIT)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .fire_cmd  (fire_cmd[i]),
            .dur       (dur_q),
            .armed     (arm_q[i]),
            .iso_ok    (iso_ok),
            .fault_clr (fault_clr[i]),
            .on        (thr_on[i]),
            .fire_st   (fire_st[i]),
            .fault     (fault_v[i]),
            .reject    (reject_v[i])
        );
    end

endmodule

// File: rtl/thr_pulse_ctrl_chk.sv
module thr_pulse_ctrl_chk #(
    parameter int unsigned N_THR    = 12,
    parameter int unsigned N_ISO    = 2,
    parameter int unsigned WD_LIMIT = 100000
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic [2:0]       reg_addr,
    input logic [31:0]      reg_wdata,
    input logic [N_THR-1:0] thr_on,
    input logic [N_THR-1:0] arm_q,
    input logic [N_ISO-1:0] iso_q,
    input logic [N_THR-1:0] fault_v,
    input logic             rej_q
);
    localparam int unsigned RUN_W = $clog2(WD_LIMIT + 1);

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (thr_on == '0 && arm_q == '0 && iso_q == '0 && !rej_q));

    a_r8_iso_close_disarms: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd3 && !(&reg_wdata[N_ISO-1:0])) |=> (arm_q == '0));

    a_r9_reject_flag: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 3'd1 && |(reg_wdata[N_THR-1:0] & ~arm_q)) |=> rej_q);

    for (genvar i = 0; i < N_THR; i++) begin : g_chk
        logic [RUN_W-1:0] run_q;

        always_ff @(posedge clk) begin
            if (rst || !thr_on[i]) run_q <= '0;
            else                   run_q <= run_q + RUN_W'(1);
        end

        a_r6_on_time_bound: assert property (@(posedge clk) disable iff (rst)
            thr_on[i] |-> (run_q < RUN_W'(WD_LIMIT)));

        a_r2_rise_after_fire: assert property (@(posedge clk) disable iff (rst)
            $rose(thr_on[i]) |-> $past(reg_wr && reg_addr == 3'd1 && reg_wdata[i]));

        a_r7_fault_sticky: assert property (@(posedge clk) disable iff (rst)
            (fault_v[i] && !(reg_wr && reg_addr == 3'd4 && reg_wdata[i])) |=> fault_v[i]);
    end

endmodule

bind thr_pulse_ctrl thr_pulse_ctrl_chk #(
    .N_THR(N_THR), .N_ISO(N_ISO), .WD_LIMIT(WD_LIMIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .thr_on    (thr_on),
    .arm_q     (arm_q),
    .iso_q     (iso_q),
    .fault_v   (fault_v),
    .rej_q     (rej_q)
);

// File: tb/thr_pulse_ctrl_tb.sv
`timescale 1ns/1ps
module thr_pulse_ctrl_tb;
    localparam int N  = 12;
    localparam int WD = 400;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] thr_on;
    logic [1:0]  iso_open;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    thr_pulse_ctrl #(.N_THR(N), .N_ISO(2), .DUR_W(8), .WD_LIMIT(WD)) u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .thr_on(thr_on), .iso_open(iso_open)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic pulse_run(input logic [N-1:0] mask, input int ch, input int nfires,
                             input int period, input int span, output int cnt);
        cnt = 0;
        for (int k = 0; k < span; k++) begin
            @(negedge clk);
            if (thr_on[ch]) cnt++;
            if ((k % period == 0) && (k / period < nfires)) begin
                reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'(mask);
            end else begin
                reg_wr = 1'b0;
            end
        end
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 thr_on", 32'(thr_on), 0);
        chk("R1 iso_open", 32'(iso_open), 0);
        rd(3'd0, d); chk("R1 arm reg", d, 0);
        rd(3'd2, d); chk("R1 dur reg", d, 0);
        rd(3'd4, d); chk("R1 status reg", d, 0);
    endtask

    task automatic t_basic();
        int c;
        logic [31:0] d;
        wr(3'd3, 3); wr(3'd2, 5); wr(3'd0, 1);
        pulse_run(12'h001, 0, 1, 12, 12, c);
        chk("R3 pulse length", c, 5);
        rd(3'd1, d); chk("R3 fire bit self-clears", d, 0);
    endtask

    task automatic t_multi();
        logic [31:0] d;
        wr(3'd2, 3); wr(3'd0, 32'hA5A);
        wr(3'd1, 32'hFFF);
        chk("R2 only armed channels open", 32'(thr_on), 32'hA5A);
        repeat (3) @(negedge clk);
        chk("R3 multi pulse ended", 32'(thr_on), 0);
        rd(3'd4, d); chk("R9 reject flag set", d, 32'h8000_0000);
        wr(3'd4, 32'h8000_0000);
        rd(3'd4, d); chk("R9 reject flag cleared", d, 0);
    endtask

    task automatic t_zero_dur();
        logic [31:0] d;
        wr(3'd2, 0); wr(3'd0, 1);
        wr(3'd1, 1);
        chk("R4 zero duration no pulse", 32'(thr_on), 0);
        repeat (3) @(negedge clk);
        chk("R4 still off", 32'(thr_on), 0);
        rd(3'd4, d); chk("R4 no reject", d, 0);
    endtask

    task automatic t_retrigger();
        int c;
        wr(3'd2, 10); wr(3'd0, 2);
        pulse_run(12'h002, 1, 2, 6, 30, c);
        chk("R5 retrigger extends pulse", c, 16);
    endtask

    task automatic t_watchdog();
        int c;
        logic [31:0] d;
        wr(3'd2, 200); wr(3'd0, 8);
        pulse_run(12'h008, 3, 6, 100, 800, c);
        chk("R6 watchdog caps on-time", c, WD);
        rd(3'd4, d); chk("R6 fault bit set", d, 32'h8);
        pulse_run(12'h008, 3, 1, 50, 50, c);
        chk("R7 faulted channel ignores fire", c, 0);
        wr(3'd4, 8);
        rd(3'd4, d); chk("R7 fault cleared", d, 0);
        pulse_run(12'h008, 3, 1, 250, 250, c);
        chk("R7 channel pulses after clear", c, 200);
    endtask

    task automatic t_iso();
        logic [31:0] d;
        wr(3'd2, 50); wr(3'd0, 4);
        wr(3'd1, 4);
        chk("R2 ch2 on", 32'(thr_on), 32'h4);
        wr(3'd3, 1);
        chk("R8 iso close kills outputs", 32'(thr_on), 0);
        chk("R8 iso outputs", 32'(iso_open), 1);
        rd(3'd0, d); chk("R8 arm cleared", d, 0);
        wr(3'd0, 4); wr(3'd1, 4);
        chk("R8 no fire while iso closed", 32'(thr_on), 0);
        rd(3'd4, d); chk("R8 armed fire not rejected", d, 0);
        wr(3'd3, 3);
        repeat (2) @(negedge clk);
        chk("R8 reopen does not resume", 32'(thr_on), 0);
    endtask

    task automatic t_disarm();
        logic [31:0] d;
        wr(3'd0, 8); wr(3'd1, 8);
        rd(3'd1, d); chk("R11 fire readback mid pulse", d, 8);
        wr(3'd0, 0);
        chk("R10 disarm drops output", 32'(thr_on), 0);
        wr(3'd0, 8);
        repeat (2) @(negedge clk);
        chk("R10 rearm does not resume", 32'(thr_on), 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(3'd2, 32'hBEEF);
        rd(3'd2, d); chk("R11 duration width", d, 32'hEF);
        rd(3'd3, d); chk("R11 iso readback", d, 3);
        rd(3'd7, d); chk("R11 unused address", d, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_multi();
        t_zero_dur();
        t_retrigger();
        t_watchdog();
        t_iso();
        t_disarm();
        t_readback();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule